// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block holds the digital control of a 10-bit successive-approximation analog-to-digital converter. Software reaches it through a small byte-wide register port. The port holds a control byte and two result bytes. The block derives a conversion period from the system clock and opens the sample/hold switch when a conversion starts. It then walks a trial code down from the most significant bit to an external DAC, and reads back one comparator bit per period. When all bits are resolved, it packs the answer into the two result bytes.

Software starts a conversion by setting the start bit while the converter is already enabled. It learns of completion from the start bit falling or from a sticky done flag, which also drives an interrupt line. Clearing the start bit mid-conversion abandons the work. A fixed two-period recovery then follows before the sample/hold reconnects. While the converter is off, the two result bytes serve as plain scratch registers.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, every register reads 0: control at address 0, high result byte at address 1, low result byte at address 2. Address 3 always reads 0. `sampleConn` and `irqOut` are low.
- R2: Control byte bits are: [0] enable, [1] start/busy, [2] right-justify, [4:3] divider select, [5] done flag. A start request is honoured only if enable was already 1 before the write carrying it. A write that turns enable on and sets start in the same byte leaves start at 0.
- R3: A conversion takes 12 conversion periods after the clock edge that accepts the start: one lead-in period, then 11 periods. On the closing edge, the result bytes are loaded, the start bit drops to 0 and the done flag rises, all together.
- R4: The first bit period begins 2 conversion periods after the start edge. Bits are decided from bit 9 down to bit 0. During a bit period, `trialCode` carries the bits kept so far, a 1 at the bit under test, and 0 below it. Before the first bit period it is 0.
- R5: A bit is kept when `cmpIn` is 1 at the end of its period. With a comparator that reports trial ≤ input, the result equals the input code.
- R6: With right-justify = 1, the high byte is {6'b0, r[9:8]} and the low byte is r[7:0]. With right-justify = 0, the high byte is r[9:2] and the low byte is {r[1:0], 6'b0}.
- R7: Writing start = 0 with enable = 1 during a conversion aborts it: the result bytes keep their values and the done flag is not set. `sampleConn` stays low for exactly 2 conversion periods after the abort edge and then rises. Start requests written during that recovery are ignored.
- R8: Software writes to the result bytes take effect and read back, including while the converter is disabled.
- R9: The done flag stays set until a control write carries 0 in bit 5. Writing 1 there leaves the flag unchanged. `irqOut` follows the flag.
- R10: A software write to a result byte during a conversion is replaced by the converted value at completion.
- R11: Divider select 0 gives a conversion period of 2 clocks, 1 gives 8 clocks, and 2 or 3 give 32 clocks.
- R12: `sampleConn` is high only when the converter is enabled and neither converting nor recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address for write and read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| cmpIn | input | 1 | Comparator decision: 1 when the trial code is not above the input |
| trialCode | output | 10 | Trial code to the DAC |
| sampleConn | output | 1 | Sample/hold switch closed (acquiring) |
| irqOut | output | 1 | Interrupt request, mirrors the done flag |

## Verification
The bench builds the block with its default divider shifts of 1, 3 and 5, which give periods of 2, 8 and 32 clocks. The short period keeps most conversions and the write-during-conversion case brief. The 8-clock period lets an abort land deep inside a conversion and still leaves room to probe the recovery window cycle by cycle. The 32-clock period shows the exact completion edge at the slowest select, and select 3 confirms it aliases to that slowest setting.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_BITS = 10;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_RECOVER} seqState_e;

  typedef struct packed {
    logic             divRun;
    logic             divRestart;
    logic             sarClear;
    logic             sarDecide;
    logic             loadResult;
    logic             trialOn;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [5:0] busWdata,
  input  logic       tadTick,
  output seqStrobe_t stb,
  output logic       abortHit,
  output logic       enable,
  output logic       goBit,
  output logic       fmtRight,
  output logic [1:0] divSel,
  output logic       doneFlag,
  output logic       sampleConn
);
  localparam logic [IDX_W-1:0] LAST_TAD = IDX_W'(RES_BITS + 1);
  localparam logic [IDX_W-1:0] FIRST_BIT_TAD = IDX_W'(2);
  localparam logic [IDX_W-1:0] RECOVER_LAST = IDX_W'(1);

  seqState_e        state;
  logic [IDX_W-1:0] tadIdx;
  logic             ctrlWr, wrEn, wrGo;
  logic             goStart, disableHit, convEnd, recEnd, bitPeriod;

  assign ctrlWr     = busWe && (busAddr == 2'd0);
  assign wrEn       = busWdata[0];
  assign wrGo       = busWdata[1];
  assign disableHit = ctrlWr && !wrEn;
  assign goStart    = ctrlWr && wrEn && wrGo && enable && (state == ST_IDLE);
  assign convEnd    = (state == ST_CONV) && tadTick && (tadIdx == LAST_TAD);
  assign abortHit   = ctrlWr && wrEn && !wrGo && (state == ST_CONV) && !convEnd;
  assign recEnd     = (state == ST_RECOVER) && tadTick && (tadIdx == RECOVER_LAST);
  assign bitPeriod  = (state == ST_CONV) && (tadIdx >= FIRST_BIT_TAD);

  always_comb begin
    stb            = '0;
    stb.divRun     = (state != ST_IDLE);
    stb.divRestart = goStart || abortHit;
    stb.sarClear   = goStart;
    stb.trialOn    = bitPeriod;
    stb.bitIdx     = bitPeriod ? IDX_W'(LAST_TAD - tadIdx) : '0;
    stb.sarDecide  = bitPeriod && tadTick;
    stb.loadResult = convEnd && !disableHit;
  end

  assign sampleConn = enable && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tadIdx <= '0;
    end else begin
      if (disableHit)          state <= ST_IDLE;
      else if (goStart)        state <= ST_CONV;
      else if (abortHit)       state <= ST_RECOVER;
      else if (stb.loadResult) state <= ST_IDLE;
      else if (recEnd)         state <= ST_IDLE;

      if (goStart || abortHit)        tadIdx <= '0;
      else if (stb.divRun && tadTick) tadIdx <= tadIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      goBit    <= 1'b0;
      fmtRight <= 1'b0;
      divSel   <= 2'd0;
      doneFlag <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable   <= wrEn;
        fmtRight <= busWdata[2];
        divSel   <= busWdata[4:3];
      end
      if (disableHit || abortHit || stb.loadResult) goBit <= 1'b0;
      else if (goStart)                             goBit <= 1'b1;

      if (stb.loadResult)              doneFlag <= 1'b1;
      else if (ctrlWr && !busWdata[5]) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int DIV_SHIFT_LO  = 1,
  parameter int DIV_SHIFT_MID = 3,
  parameter int DIV_SHIFT_HI  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [1:0]          divSel,
  input  logic                fmtRight,
  input  logic                cmpIn,
  input  logic                busWe,
  input  logic [1:0]          busAddr,
  input  logic [7:0]          busWdata,
  output logic                tadTick,
  output logic [RES_BITS-1:0] trialCode,
  output logic [7:0]          resHi,
  output logic [7:0]          resLo
);
  localparam int CNT_W = DIV_SHIFT_HI;
  localparam int PAD_W = 16 - RES_BITS;

  logic [CNT_W-1:0]    divCnt, divLast;
  logic [RES_BITS-1:0] sarReg, trialMask, finalCode;
  logic [15:0]         packed16;

  always_comb begin
    case (divSel)
      2'd0:    divLast = CNT_W'((32'd1 << DIV_SHIFT_LO) - 32'd1);
      2'd1:    divLast = CNT_W'((32'd1 << DIV_SHIFT_MID) - 32'd1);
      default: divLast = CNT_W'((32'd1 << DIV_SHIFT_HI) - 32'd1);
    endcase
  end

  assign tadTick = stb.divRun && (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divCnt <= '0;
    else if (stb.divRestart) divCnt <= '0;
    else if (!stb.divRun)    divCnt <= '0;
    else if (tadTick)        divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  for (genvar g = 0; g < RES_BITS; g++) begin : g_mask
    assign trialMask[g] = stb.trialOn && (stb.bitIdx == IDX_W'(g));
  end

  assign trialCode = sarReg | trialMask;
  assign finalCode = sarReg | (cmpIn ? trialMask : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      sarReg <= '0;
    else if (stb.sarClear)          sarReg <= '0;
    else if (stb.sarDecide && cmpIn) sarReg <= sarReg | trialMask;
  end

  assign packed16 = fmtRight ? {{PAD_W{1'b0}}, finalCode}
                             : {finalCode, {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHi <= '0;
      resLo <= '0;
    end else if (stb.loadResult) begin
      resHi <= packed16[15:8];
      resLo <= packed16[7:0];
    end else if (busWe) begin
      if (busAddr == 2'd1) resHi <= busWdata;
      if (busAddr == 2'd2) resLo <= busWdata;
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int DIV_SHIFT_LO  = 1,
  parameter int DIV_SHIFT_MID = 3,
  parameter int DIV_SHIFT_HI  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [1:0]          busAddr,
  input  logic [7:0]          busWdata,
  output logic [7:0]          busRdata,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] trialCode,
  output logic                sampleConn,
  output logic                irqOut
);
  seqStrobe_t stb;
  logic       tadTick, abortHit, enable, goBit, fmtRight, doneFlag;
  logic [1:0] divSel;
  logic [7:0] resHi, resLo;

  sar_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata[5:0]), .tadTick(tadTick), .stb(stb),
    .abortHit(abortHit), .enable(enable), .goBit(goBit),
    .fmtRight(fmtRight), .divSel(divSel), .doneFlag(doneFlag),
    .sampleConn(sampleConn)
  );

  sar_datapath #(
    .DIV_SHIFT_LO(DIV_SHIFT_LO), .DIV_SHIFT_MID(DIV_SHIFT_MID),
    .DIV_SHIFT_HI(DIV_SHIFT_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .divSel(divSel),
    .fmtRight(fmtRight), .cmpIn(cmpIn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .tadTick(tadTick),
    .trialCode(trialCode), .resHi(resHi), .resLo(resLo)
  );

  always_comb begin
    case (busAddr)
      2'd0:    busRdata = {2'b00, doneFlag, divSel, fmtRight, goBit, enable};
      2'd1:    busRdata = resHi;
      2'd2:    busRdata = resLo;
      default: busRdata = 8'h00;
    endcase
  end

  assign irqOut = doneFlag;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
  import sar_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input seqStrobe_t          stb,
  input logic                abortHit,
  input logic                enable,
  input logic                goBit,
  input logic                fmtRight,
  input logic                doneFlag,
  input logic                sampleConn,
  input logic [RES_BITS-1:0] trialCode,
  input logic [7:0]          resHi,
  input logic [7:0]          resLo
);
  // R2: a live start bit implies the converter is on
  p_go_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    goBit |-> enable);

  // R12: switch open whenever a conversion is in flight
  p_sample_open_r12: assert property (@(posedge clk) disable iff (!rstN)
    goBit |-> !sampleConn);

  // R3: completion drops start and raises the flag together
  p_done_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadResult |=> (!goBit && doneFlag));

  // R7: abort leaves both result bytes alone
  p_abort_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortHit |=> (resHi == $past(resHi) && resLo == $past(resLo) && !goBit));

  // R6: zero fill, right-justified
  p_fill_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadResult && fmtRight) |=> (resHi[7:2] == 6'd0));

  // R6: zero fill, left-justified
  p_fill_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadResult && !fmtRight) |=> (resLo[5:0] == 6'd0));

  // R4: bit under test is driven high
  p_trial_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.trialOn |-> trialCode[stb.bitIdx]);
endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .abortHit(abortHit),
  .enable(enable), .goBit(goBit), .fmtRight(fmtRight),
  .doneFlag(doneFlag), .sampleConn(sampleConn), .trialCode(trialCode),
  .resHi(resHi), .resLo(resLo)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [9:0] trialCode;
  logic [9:0] vin = 10'd0;
  logic       cmpIn, sampleConn, irqOut;

  int vecCnt = 0;
  int missCnt = 0;
  int pushCnt = 0;
  int popCnt = 0;
  bit finished = 0;

  typedef struct { logic [7:0] hi; logic [7:0] lo; string tag; } expItem_t;
  expItem_t expQ[$];
  event doneEv;

  always #10 clk = ~clk;

  assign cmpIn = (trialCode <= vin);

  sar_adc_seq u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmpIn(cmpIn),
    .trialCode(trialCode), .sampleConn(sampleConn), .irqOut(irqOut)
  );

  function automatic logic [7:0] ctl(bit en, bit go, bit rj, logic [1:0] dv, bit fl);
    return {2'b00, fl, dv, rj, go, en};
  endfunction

  function automatic int periodOf(logic [1:0] dv);
    return (dv == 2'd0) ? 2 : (dv == 2'd1) ? 8 : 32;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after capture
  task automatic wr(logic [1:0] a, logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic runConv(logic [9:0] v, bit rj, logic [1:0] dv, bit poke);
    int n = periodOf(dv);
    logic [7:0] r;
    expItem_t it;
    vin = v;
    it.hi = rj ? {6'b0, v[9:8]} : v[9:2];
    it.lo = rj ? v[7:0] : {v[1:0], 6'b0};
    it.tag = poke ? "R10 R5 R6" : "R5 R6";
    expQ.push_back(it);
    pushCnt++;
    wr(2'd0, ctl(1, 1, rj, dv, 0));
    rd(2'd0, r);
    check("R2 start accepted", 16'(r[1]), 16'd1);
    if (poke) begin
      wr(2'd1, 8'hFF);
      repeat (12 * n - 2) @(negedge clk);
    end else begin
      repeat (2 * n - 1) @(negedge clk);
      check("R4 trial before first bit", 16'(trialCode), 16'h000);
      @(negedge clk);
      check("R4 trial first bit", 16'(trialCode), 16'h200);
      repeat (10 * n - 1) @(negedge clk);
    end
    rd(2'd0, r);
    check("R3 R11 busy one clock before end", 16'(r[1]), 16'd1);
    check("R12 switch open while busy", 16'(sampleConn), 16'd0);
    @(negedge clk);
    rd(2'd0, r);
    check("R3 R11 start bit cleared at end", 16'(r[1]), 16'd0);
    check("R3 done flag at end", 16'(r[5]), 16'd1);
    check("R9 irq follows flag", 16'(irqOut), 16'd1);
    check("R12 switch closed after end", 16'(sampleConn), 16'd1);
    -> doneEv;
    wait (popCnt == pushCnt);
    @(negedge clk);
    wr(2'd0, ctl(1, 0, rj, dv, 1));
    check("R9 writing 1 keeps flag", 16'(irqOut), 16'd1);
    wr(2'd0, ctl(1, 0, rj, dv, 0));
    check("R9 writing 0 clears flag", 16'(irqOut), 16'd0);
  endtask

  // monitor: pops expected result bytes and compares at each completion
  initial begin
    forever begin
      expItem_t it;
      logic [7:0] h, l;
      @(doneEv);
      it = expQ.pop_front();
      rd(2'd1, h);
      rd(2'd2, l);
      check({it.tag, " high byte"}, 16'(h), 16'(it.hi));
      check({it.tag, " low byte"}, 16'(l), 16'(it.lo));
      popCnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      missCnt++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, r); check("R1 control reset", 16'(r), 16'h00);
    rd(2'd1, r); check("R1 high reset", 16'(r), 16'h00);
    rd(2'd2, r); check("R1 low reset", 16'(r), 16'h00);
    rd(2'd3, r); check("R1 spare address", 16'(r), 16'h00);
    check("R1 switch reset", 16'(sampleConn), 16'd0);
    check("R1 irq reset", 16'(irqOut), 16'd0);
    @(negedge clk);

    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hC3);
    rd(2'd1, r); check("R8 scratch high", 16'(r), 16'h5A);
    rd(2'd2, r); check("R8 scratch low", 16'(r), 16'hC3);
    @(negedge clk);

    wr(2'd0, ctl(1, 1, 0, 0, 0));
    rd(2'd0, r);
    check("R2 start in enabling write ignored", 16'(r), 16'h01);
    repeat (4) @(negedge clk);
    rd(2'd0, r); check("R2 still idle", 16'(r[1]), 16'd0);
    check("R12 switch closed when enabled idle", 16'(sampleConn), 16'd1);
    @(negedge clk);

    runConv(10'h2AA, 1, 2'd0, 0);
    runConv(10'h155, 0, 2'd1, 0);
    runConv(10'h3FF, 1, 2'd2, 0);
    runConv(10'h000, 0, 2'd0, 0);
    runConv(10'h001, 1, 2'd3, 0);
    runConv(10'h2C3, 0, 2'd0, 1);

    // R7 abort with an 8-clock period; prior result is B0/C0
    vin = 10'h0F0;
    wr(2'd0, ctl(1, 1, 1, 2'd1, 0));
    repeat (40) @(negedge clk);
    wr(2'd0, ctl(1, 0, 1, 2'd1, 0));
    rd(2'd0, r); check("R7 start cleared by abort", 16'(r[1]), 16'd0);
    wr(2'd0, ctl(1, 1, 1, 2'd1, 0));
    rd(2'd0, r); check("R7 start during recovery ignored", 16'(r[1]), 16'd0);
    repeat (14) @(negedge clk);
    check("R7 switch open at last recovery clock", 16'(sampleConn), 16'd0);
    @(negedge clk);
    check("R7 switch closes after two periods", 16'(sampleConn), 16'd1);
    rd(2'd1, r); check("R7 high byte kept", 16'(r), 16'hB0);
    rd(2'd2, r); check("R7 low byte kept", 16'(r), 16'hC0);
    check("R7 no flag on abort", 16'(irqOut), 16'd0);
    @(negedge clk);
    runConv(10'h0F0, 1, 2'd1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end
endmodule